// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating dual-slope analog-to-digital converter. A start request is taken only while the block is idle. The block first holds the integrator capacitor in reset for a fixed number of cycles. It then connects the integrator to the unknown input for a fixed number of clock ticks. After that it connects the integrator to the negative reference and times how long the integrator takes to run back down to zero.

The elapsed discharge time, counted in clock cycles, is the conversion result. For a fixed integrate length it grows in proportion to the input voltage. The comparator that detects the zero crossing is asynchronous to the clock, so it passes through a synchronizer chain before the sequencer uses it. If no crossing is seen before the discharge counter is full, the conversion stops, the result saturates and an overrange flag is set.

The analog switches, integrator and comparator are outside the block. The output `sel_vin` drives the input switch, `sel_vref` drives the reference switch and `int_rst` drives the capacitor discharge switch.

Top module: `dslope_ctrl`

## Requirements
- R1: After the reset phase, `sel_vin` is high for exactly INT_TICKS consecutive cycles, and `sel_vref` stays low during those cycles.
- R2: In the cycle after the last integrate cycle, `sel_vin` is low and `sel_vref` is high. `sel_vref` stays high until the discharge ends.
- R3: The discharge counter is zero in the first discharge cycle and rises by one in each later discharge cycle.
- R4: The discharge ends in the first discharge cycle in which the synchronized comparator is high. The counter value in that cycle becomes `result`, and the DONE cycle follows.
- R5: `result` and `overrange` change only when a conversion ends. They hold their values through the next conversion until its DONE cycle.
- R6: Once a start is accepted, `int_rst` is high for exactly RST_CYCLES cycles, directly before the first integrate cycle.
- R7: If the counter reaches all ones (2^CNT_W-1) and no comparator trip is seen in that cycle, the conversion ends with `result` all ones and `overrange` set to 1. A later conversion that trips normally clears `overrange` to 0.
- R8: `cmp_zero` passes through SYNC_STAGES flops. A comparator level present in cycle k is acted on in cycle k+SYNC_STAGES. With the default of 2 stages, this gives `result` = ceil(INT_TICKS·vin/vref)+1 for a linear integrator model with vin>0.
- R9: `busy` is high in every cycle from the first reset cycle through the DONE cycle. `done` is high for exactly one cycle per conversion. A start seen while `busy` is high is ignored.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only while idle |
| cmp_zero | input | 1 | Asynchronous comparator level, 1 when the integrator is at or below zero |
| sel_vin | output | 1 | Connects the integrator to the unknown input |
| sel_vref | output | 1 | Connects the integrator to the negative reference |
| int_rst | output | 1 | Shorts the integrator capacitor |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | CNT_W | Discharge count of the last conversion |
| overrange | output | 1 | The last conversion saturated without a comparator trip |

## Verification
Some checks run on every cycle of every run. They cover:
- the length of the integrate phase;
- the hand-over from the input switch to the reference switch;
- the counter being zero at the start of discharge;
- the stop on a synchronized trip;
- the single-cycle `done` pulse;
- the saturated value that goes with `overrange`;
- the rule that an active conversion never falls straight back to idle.

Other behaviour shows only in the bench's scenarios against its behavioural integrator:
- the proportional result, including its synchronizer latency;
- the zero-input result of 0;
- the full 2^CNT_W-cycle discharge on overrange and the flag clearing on the next conversion;
- a start pulse in mid-conversion having no effect.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RESET_INT,
      ST_INTEGRATE,
      ST_DEINTEGRATE,
      ST_DONE
   } dslope_state_t;
endpackage

// File: rtl/dslope_sync.sv
// Multi-flop synchronizer for the asynchronous comparator level.
module dslope_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dslope_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dslope_counter.sv
// Up counter with synchronous clear and a full-scale flag.
module dslope_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_max
);
   if (W < 1) begin : g_bad_width
      $error("dslope_counter: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

   assign at_max = (cnt == {W{1'b1}});
endmodule

// File: rtl/dslope_seq.sv
// Phase sequencer: reset, fixed integrate, timed discharge, done.
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int PH_W       = 5,
   parameter int INT_TICKS  = 16,
   parameter int RST_CYCLES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cmp_s,
   input  logic [PH_W-1:0]     ph_cnt,
   input  logic [CNT_W-1:0]    res_cnt,
   input  logic                res_max,
   output dslope_state_t       state,
   output logic                ph_clr,
   output logic                ph_en,
   output logic                res_clr,
   output logic                res_en,
   output logic [CNT_W-1:0]    result,
   output logic                overrange
);
   localparam logic [PH_W-1:0] RST_LAST = PH_W'(RST_CYCLES - 1);
   localparam logic [PH_W-1:0] INT_LAST = PH_W'(INT_TICKS - 1);

   dslope_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:        if (start) nxt = ST_RESET_INT;
         ST_RESET_INT:   if (ph_cnt == RST_LAST) nxt = ST_INTEGRATE;
         ST_INTEGRATE:   if (ph_cnt == INT_LAST) nxt = ST_DEINTEGRATE;
         ST_DEINTEGRATE: if (cmp_s || res_max) nxt = ST_DONE;
         ST_DONE:        nxt = ST_IDLE;
         default:        nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // Phase timer restarts on every state change.
   assign ph_clr  = (nxt != state);
   assign ph_en   = (state == ST_RESET_INT) || (state == ST_INTEGRATE);
   assign res_clr = (nxt == ST_DEINTEGRATE) && (state != ST_DEINTEGRATE);
   assign res_en  = (state == ST_DEINTEGRATE) && (nxt == ST_DEINTEGRATE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         overrange <= 1'b0;
      end else if (state == ST_DEINTEGRATE && nxt == ST_DONE) begin
         result    <= cmp_s ? res_cnt : {CNT_W{1'b1}};
         overrange <= !cmp_s;
      end
   end

   AST_INT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INTEGRATE && nxt != ST_INTEGRATE) |-> ph_cnt == INT_LAST); // R1
   AST_STOP_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEINTEGRATE && cmp_s) |=> (state == ST_DONE && result == $past(res_cnt))); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> (state == ST_IDLE)); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE)); // R9
endmodule

// File: rtl/dslope_ctrl.sv
// Top: dual-slope converter control and counting.
module dslope_ctrl
   import dslope_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int INT_TICKS   = 16,
   parameter int RST_CYCLES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_zero,
   output logic             sel_vin,
   output logic             sel_vref,
   output logic             int_rst,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] result,
   output logic             overrange
);
   localparam int PH_MAX = (INT_TICKS > RST_CYCLES) ? INT_TICKS : RST_CYCLES;
   localparam int PH_W   = $clog2(PH_MAX + 1);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("dslope_ctrl: CNT_W out of range");
   end
   if (INT_TICKS < 1) begin : g_bad_int
      $error("dslope_ctrl: INT_TICKS must be at least 1");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("dslope_ctrl: RST_CYCLES must be at least 1");
   end

   logic                cmp_s;
   logic [PH_W-1:0]     ph_cnt;
   logic                ph_max_unused;
   logic [CNT_W-1:0]    res_cnt;
   logic                res_max;
   logic                ph_clr, ph_en, res_clr, res_en;
   dslope_state_t       state;

   dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_zero), .q(cmp_s)
   );

   dslope_counter #(.W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(ph_en),
      .cnt(ph_cnt), .at_max(ph_max_unused)
   );

   dslope_counter #(.W(CNT_W)) u_disch (
      .clk(clk), .rst_n(rst_n), .clr(res_clr), .en(res_en),
      .cnt(res_cnt), .at_max(res_max)
   );

   dslope_seq #(
      .CNT_W(CNT_W), .PH_W(PH_W), .INT_TICKS(INT_TICKS), .RST_CYCLES(RST_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_s(cmp_s),
      .ph_cnt(ph_cnt), .res_cnt(res_cnt), .res_max(res_max),
      .state(state), .ph_clr(ph_clr), .ph_en(ph_en),
      .res_clr(res_clr), .res_en(res_en),
      .result(result), .overrange(overrange)
   );

   assign int_rst  = (state == ST_RESET_INT);
   assign sel_vin  = (state == ST_INTEGRATE);
   assign sel_vref = (state == ST_DEINTEGRATE);
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);

   AST_VREF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_vin) |-> sel_vref); // R2
   AST_DEINT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_vref) |-> (res_cnt == '0)); // R3
   AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      overrange |-> (result == {CNT_W{1'b1}})); // R7
   AST_RST_THEN_INT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> sel_vin); // R6
endmodule

// File: tb/sim_dslope_ctrl.sv
module sim_dslope_ctrl;
   localparam int CNT_W = 8;
   localparam int N     = 16;
   localparam int RSTC  = 3;
   localparam int SYNC  = 2;
   localparam int MAXV  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cmp_zero = 1'b1;
   logic sel_vin, sel_vref, int_rst, busy, done, overrange;
   logic [CNT_W-1:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // behavioural analog model
   int integ = 0;
   int vin = 0;
   int vref = 1;
   int cnt_vin = 0, cnt_vref = 0, cnt_rst = 0, cnt_done = 0;

   // reference model state: 0 idle, 1 reset, 2 integrate, 3 discharge, 4 done
   int m_st = 0, m_ph = 0, m_cnt = 0, m_res = 0, m_ovr = 0;
   bit sq[$];

   always #10 clk = ~clk;

   dslope_ctrl #(.CNT_W(CNT_W), .INT_TICKS(N), .RST_CYCLES(RSTC), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_zero(cmp_zero),
      .sel_vin(sel_vin), .sel_vref(sel_vref), .int_rst(int_rst),
      .busy(busy), .done(done), .result(result), .overrange(overrange)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   // reference model, advanced at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ph = 0; m_cnt = 0; m_res = 0; m_ovr = 0;
         sq.delete();
         for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
      end else begin
         case (m_st)
            0: if (start) begin m_st = 1; m_ph = 0; end
            1: if (m_ph == RSTC - 1) begin m_st = 2; m_ph = 0; end else m_ph++;
            2: if (m_ph == N - 1) begin m_st = 3; m_cnt = 0; end else m_ph++;
            3: begin
               if (sq[0]) begin m_res = m_cnt; m_ovr = 0; m_st = 4; end
               else if (m_cnt == MAXV) begin m_res = MAXV; m_ovr = 1; m_st = 4; end
               else m_cnt++;
            end
            default: m_st = 0;
         endcase
         void'(sq.pop_front());
         sq.push_back(cmp_zero);
      end
   end

   // compare every cycle, then advance the analog model
   always @(negedge clk) begin
      cyc++;
      chk("R10/R9 busy", busy, m_st != 0);
      chk("R9 done", done, m_st == 4);
      chk("R6 int_rst", int_rst, m_st == 1);
      chk("R1 sel_vin", sel_vin, m_st == 2);
      chk("R2 sel_vref", sel_vref, m_st == 3);
      chk("R4/R5 result", result, m_res);
      chk("R7 overrange", overrange, m_ovr);
      if (int_rst) integ = 0;
      else if (sel_vin) integ += vin;
      else if (sel_vref) integ -= vref;
      cmp_zero = (integ <= 0);
      if (sel_vin) cnt_vin++;
      if (sel_vref) cnt_vref++;
      if (int_rst) cnt_rst++;
      if (done) cnt_done++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic conv(int vi, int vr, bit extra_start);
      int t, exp_res, exp_ovr, q;
      @(negedge clk);
      vin = vi; vref = vr;
      cnt_vin = 0; cnt_vref = 0; cnt_rst = 0; cnt_done = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (done !== 1'b1 && t < 2000) begin
         @(negedge clk);
         t++;
         start = (extra_start && (t == 5 || t == N + 6)); // R9 start while busy
      end
      start = 1'b0;
      if (vi == 0) begin exp_res = 0; exp_ovr = 0; end
      else if (vr == 0) begin exp_res = MAXV; exp_ovr = 1; end
      else begin
         q = (N * vi + vr - 1) / vr + SYNC - 1; // R8 latency
         if (q > MAXV) begin exp_res = MAXV; exp_ovr = 1; end
         else begin exp_res = q; exp_ovr = 0; end
      end
      chk("R4/R8 result at done", result, exp_res);
      chk("R7 overrange at done", overrange, exp_ovr);
      chk("R1 integrate cycles", cnt_vin, N);
      chk("R6 reset cycles", cnt_rst, RSTC);
      chk("R3 discharge cycles", cnt_vref, exp_res + 1);
      repeat (4) @(negedge clk);
      chk("R9 single done", cnt_done, 1);
      chk("R9 idle after done", busy, 0);
      chk("R5 result held", result, exp_res);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset result", result, 0);
      chk("R10 reset busy", busy, 0);
      chk("R10 reset selects", {sel_vin, sel_vref, int_rst, done, overrange}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      conv(10, 4, 1'b0);
      conv(1, 4, 1'b0);
      conv(3, 7, 1'b1);
      conv(0, 4, 1'b0);
      conv(5, 0, 1'b0);
      conv(63, 4, 1'b1);
      conv(1, 1, 1'b0);
      conv(40, 2, 1'b0);
      conv(2, 3, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule